// File: doc/BRIEF.md
# Codec Time-Slot Selector for a Time-Division Serial Bus

This block connects an internal voice codec to one 8-bit time slot of a time-division serial bus. The bus has a downstream data line, an upstream data line, a data clock that runs at twice the bit rate, and an 8 kHz frame sync. Each frame holds twelve bytes in three subframes of four. The two voice slots are at byte positions 0 and 1 of subframe 0. The two intra-chip slots are at positions 0 and 1 of subframe 1, which are frame bytes 4 and 5.

Once per frame the block sends the codec's transmit byte in the chosen slot and captures one byte for the codec. The transmit line and the receive line depend on the slot and on a direction-reversal option. That option works only for the intra-chip slots and only in terminal mode. A loopback mode returns the transmitted byte to the codec receive path and ignores both bus inputs.

The bus signals (`dcl`, `fsc`, `dd_in`, `du_in`) must already be synchronous to `clk`, and `clk` must run at least twice as fast as `dcl`. Edges of `dcl` are detected in the `clk` domain. A line is driven with `tx_bit` while its enable is high. Otherwise the line is released, and the external pull-up holds it high.

Top module: `tdm_codec_slot`

## Requirements
- R1: After reset, `dd_en`, `du_en`, `codec_rx_valid` and `codec_rx` are 0, `tx_bit` is 1, and no line is driven until the first frame start.
- R2: The slot code `cfg_slot` maps as follows: 2'b10 selects frame byte 0 (B1), 2'b11 selects byte 1 (B2), 2'b00 selects byte 4 (IC1) and 2'b01 selects byte 5 (IC2). Exactly one line enable is high for the 16 data-clock periods of the selected byte, and both enables are low for the rest of the 192-period frame.
- R3: Each bit takes two data-clock periods and is sent MSB first. `tx_bit` and the enables change only on a rising data-clock edge, one `clk` after it is seen. `codec_tx` and all four configuration inputs are latched at the first rising edge of each frame, so changes made later in the frame take effect in the next frame.
- R4: Without active reversal, the block drives the upstream line (`du_en`) and captures from `dd_in`.
- R5: With `cfg_reverse`=1, `term_mode`=1 and an intra-chip slot selected, the block drives the downstream line (`dd_en`) and captures from `du_in`.
- R6: For the B1 and B2 slots, `cfg_reverse` has no effect: the block drives upstream and captures downstream.
- R7: With `term_mode`=0, `cfg_reverse` has no effect on any slot.
- R8: With `cfg_loopback`=1, the captured byte equals the transmitted byte of the frame, and `dd_in` and `du_in` are ignored.
- R9: Each received bit is sampled on the falling data-clock edge in the second period of the bit. After the slot's last bit, `codec_rx` is updated and `codec_rx_valid` pulses for exactly one `clk`, once per frame.
- R10: A rising `fsc` seen at a rising data-clock edge makes that edge the first half of bit 0 of byte 0. A slot cut short by this realignment produces no valid strobe, and the next complete frame captures correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least twice the data-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| dcl | input | 1 | Bus data clock (twice the bit rate), synchronous to clk |
| fsc | input | 1 | Bus frame sync, sampled on rising dcl |
| dd_in | input | 1 | Downstream line as seen on the bus |
| du_in | input | 1 | Upstream line as seen on the bus |
| dd_en | output | 1 | Drive enable for the downstream line |
| du_en | output | 1 | Drive enable for the upstream line |
| tx_bit | output | 1 | Bit value to place on the enabled line (1 when idle) |
| cfg_slot | input | 2 | Slot code (see R2) |
| cfg_reverse | input | 1 | Direction reversal for the intra-chip slots |
| term_mode | input | 1 | Terminal mode; reversal is honoured only when 1 |
| cfg_loopback | input | 1 | Local loopback of the transmitted byte |
| codec_tx | input | 8 | Byte from the codec to send this frame |
| codec_rx | output | 8 | Last byte captured for the codec |
| codec_rx_valid | output | 1 | One-cycle strobe when codec_rx is updated |

## Verification
Frame-sync realignment and slot capture can fall in the same cycle. A rising sync can arrive while the selected slot is half shifted in, so the counters jump while the receive shift register holds a partial byte. The bench selects IC1 and raises sync at the rising edge of bit 3 of that slot. It then expects no valid strobe in the cut frame and the correct byte in the next full frame. Configuration latching and the first driven bit also share a cycle: with B1 selected, the edge that latches a new slot code and transmit byte also places the first bit. The bench changes both inputs mid-frame and judges every driven bit against the values held at the previous frame start.

// File: rtl/tdm_codec_pkg.sv
package tdm_codec_pkg;

  // Slot codes as carried on the configuration inputs.
  typedef enum logic [1:0] {
    SEL_IC1 = 2'b00,
    SEL_IC2 = 2'b01,
    SEL_B1  = 2'b10,
    SEL_B2  = 2'b11
  } slot_sel_e;

  typedef struct packed {
    slot_sel_e sel;
    logic      rev;
    logic      term;
    logic      loop;
  } slot_cfg_t;

  // True for the intra-chip slots, which sit in the second subframe.
  function automatic logic is_intra(input slot_sel_e sel);
    return (sel == SEL_IC1) || (sel == SEL_IC2);
  endfunction

  // Frame byte index of a slot; intra-chip slots start one subframe in.
  function automatic int slot_offset(input slot_sel_e sel, input int sub_bytes);
    int base;
    base = is_intra(sel) ? sub_bytes : 0;
    return base + (((sel == SEL_IC2) || (sel == SEL_B2)) ? 1 : 0);
  endfunction

  // The block drives the downstream line only for a reversed intra-chip slot in terminal mode.
  function automatic logic drives_down(input slot_cfg_t cfg);
    return is_intra(cfg.sel) && cfg.rev && cfg.term;
  endfunction

endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer #(
  parameter int DATA_W      = 8,
  parameter int FRAME_BYTES = 12,
  localparam int BIT_W  = $clog2(DATA_W),
  localparam int BYTE_W = $clog2(FRAME_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dcl,
  input  logic              fsc,
  output logic              rise,
  output logic              fall,
  output logic              resync,
  output logic              frame_start,
  output logic              nxt_phase,
  output logic [BIT_W-1:0]  nxt_bit,
  output logic [BYTE_W-1:0] nxt_byte,
  output logic              cur_phase,
  output logic [BIT_W-1:0]  cur_bit,
  output logic [BYTE_W-1:0] cur_byte
);

  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(DATA_W - 1);
  localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(FRAME_BYTES - 1);

  logic dcl_q;
  logic fsc_at_rise;

  assign rise   = dcl & ~dcl_q;
  assign fall   = ~dcl & dcl_q;
  assign resync = rise & fsc & ~fsc_at_rise;

  // Next bus position, applied on each rising data-clock edge.
  always_comb begin
    nxt_phase = cur_phase;
    nxt_bit   = cur_bit;
    nxt_byte  = cur_byte;
    if (rise) begin
      if (resync) begin
        nxt_phase = 1'b0;
        nxt_bit   = '0;
        nxt_byte  = '0;
      end else if (!cur_phase) begin
        nxt_phase = 1'b1;
      end else begin
        nxt_phase = 1'b0;
        if (cur_bit == LAST_BIT) begin
          nxt_bit  = '0;
          nxt_byte = (cur_byte == LAST_BYTE) ? '0 : cur_byte + 1'b1;
        end else begin
          nxt_bit = cur_bit + 1'b1;
        end
      end
    end
  end

  assign frame_start = rise && !nxt_phase && (nxt_bit == '0) && (nxt_byte == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcl_q       <= 1'b0;
      fsc_at_rise <= 1'b0;
      cur_phase   <= 1'b1;
      cur_bit     <= LAST_BIT;
      cur_byte    <= LAST_BYTE;
    end else begin
      dcl_q <= dcl;
      if (rise) fsc_at_rise <= fsc;
      cur_phase <= nxt_phase;
      cur_bit   <= nxt_bit;
      cur_byte  <= nxt_byte;
    end
  end

endmodule

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx #(
  parameter int DATA_W = 8,
  parameter int BIT_W  = 3,
  parameter int BYTE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              frame_start,
  input  logic [BIT_W-1:0]  nxt_bit,
  input  logic [BYTE_W-1:0] nxt_byte,
  input  logic [BYTE_W-1:0] slot_nx,
  input  logic              down_nx,
  input  logic [DATA_W-1:0] codec_tx,
  output logic              dd_en,
  output logic              du_en,
  output logic              tx_bit
);

  logic [DATA_W-1:0] hold;
  logic [DATA_W-1:0] hold_nx;
  logic              in_slot_nx;

  assign hold_nx    = frame_start ? codec_tx : hold;
  assign in_slot_nx = (nxt_byte == slot_nx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold   <= '0;
      dd_en  <= 1'b0;
      du_en  <= 1'b0;
      tx_bit <= 1'b1;
    end else if (rise) begin
      hold   <= hold_nx;
      dd_en  <= in_slot_nx & down_nx;
      du_en  <= in_slot_nx & ~down_nx;
      tx_bit <= in_slot_nx ? hold_nx[BIT_W'(DATA_W - 1) - nxt_bit] : 1'b1;
    end
  end

endmodule

// File: rtl/tdm_slot_rx.sv
module tdm_slot_rx #(
  parameter int DATA_W = 8,
  parameter int BIT_W  = 3,
  parameter int BYTE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall,
  input  logic              cur_phase,
  input  logic [BIT_W-1:0]  cur_bit,
  input  logic [BYTE_W-1:0] cur_byte,
  input  logic [BYTE_W-1:0] slot_q,
  input  logic              down_q,
  input  logic              loop_q,
  input  logic              tx_bit,
  input  logic              dd_in,
  input  logic              du_in,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid
);

  logic [DATA_W-2:0] shreg;
  logic              bit_in;
  logic              take;

  // Loopback takes the bit being driven; otherwise the line opposite the driven one.
  assign bit_in = loop_q ? tx_bit : (down_q ? du_in : dd_in);
  assign take   = fall && cur_phase && (cur_byte == slot_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (take) begin
        shreg <= {shreg[DATA_W-3:0], bit_in};
        if (cur_bit == BIT_W'(DATA_W - 1)) begin
          rx_data  <= {shreg, bit_in};
          rx_valid <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/tdm_codec_slot.sv
module tdm_codec_slot
  import tdm_codec_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int FRAME_BYTES    = 12,
  parameter int SUBFRAME_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dcl,
  input  logic              fsc,
  input  logic              dd_in,
  input  logic              du_in,
  output logic              dd_en,
  output logic              du_en,
  output logic              tx_bit,
  input  logic [1:0]        cfg_slot,
  input  logic              cfg_reverse,
  input  logic              term_mode,
  input  logic              cfg_loopback,
  input  logic [DATA_W-1:0] codec_tx,
  output logic [DATA_W-1:0] codec_rx,
  output logic              codec_rx_valid
);

  localparam int BIT_W  = $clog2(DATA_W);
  localparam int BYTE_W = $clog2(FRAME_BYTES);

  logic              rise, fall, resync, frame_start;
  logic              nxt_phase, cur_phase;
  logic [BIT_W-1:0]  nxt_bit, cur_bit;
  logic [BYTE_W-1:0] nxt_byte, cur_byte;

  slot_cfg_t cfg_in, cfg_q, cfg_nx;
  logic [BYTE_W-1:0] slot_nx, slot_q;
  logic              down_nx, down_q;

  // Named internal events for the checker.
  logic cfg_intra_q, cfg_rev_q, cfg_term_q, at_frame_head;

  tdm_frame_timer #(
    .DATA_W     (DATA_W),
    .FRAME_BYTES(FRAME_BYTES)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .dcl        (dcl),
    .fsc        (fsc),
    .rise       (rise),
    .fall       (fall),
    .resync     (resync),
    .frame_start(frame_start),
    .nxt_phase  (nxt_phase),
    .nxt_bit    (nxt_bit),
    .nxt_byte   (nxt_byte),
    .cur_phase  (cur_phase),
    .cur_bit    (cur_bit),
    .cur_byte   (cur_byte)
  );

  assign cfg_in = '{sel: slot_sel_e'(cfg_slot), rev: cfg_reverse,
                    term: term_mode, loop: cfg_loopback};
  assign cfg_nx = frame_start ? cfg_in : cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '{sel: SEL_IC1, rev: 1'b0, term: 1'b0, loop: 1'b0};
    else if (frame_start) cfg_q <= cfg_in;
  end

  assign slot_nx = BYTE_W'(slot_offset(cfg_nx.sel, SUBFRAME_BYTES));
  assign slot_q  = BYTE_W'(slot_offset(cfg_q.sel, SUBFRAME_BYTES));
  assign down_nx = drives_down(cfg_nx);
  assign down_q  = drives_down(cfg_q);

  assign cfg_intra_q   = is_intra(cfg_q.sel);
  assign cfg_rev_q     = cfg_q.rev;
  assign cfg_term_q    = cfg_q.term;
  assign at_frame_head = !cur_phase && (cur_bit == '0) && (cur_byte == '0);

  tdm_slot_tx #(
    .DATA_W(DATA_W),
    .BIT_W (BIT_W),
    .BYTE_W(BYTE_W)
  ) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise       (rise),
    .frame_start(frame_start),
    .nxt_bit    (nxt_bit),
    .nxt_byte   (nxt_byte),
    .slot_nx    (slot_nx),
    .down_nx    (down_nx),
    .codec_tx   (codec_tx),
    .dd_en      (dd_en),
    .du_en      (du_en),
    .tx_bit     (tx_bit)
  );

  tdm_slot_rx #(
    .DATA_W(DATA_W),
    .BIT_W (BIT_W),
    .BYTE_W(BYTE_W)
  ) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .fall     (fall),
    .cur_phase(cur_phase),
    .cur_bit  (cur_bit),
    .cur_byte (cur_byte),
    .slot_q   (slot_q),
    .down_q   (down_q),
    .loop_q   (cfg_q.loop),
    .tx_bit   (tx_bit),
    .dd_in    (dd_in),
    .du_in    (du_in),
    .rx_data  (codec_rx),
    .rx_valid (codec_rx_valid)
  );

endmodule

// File: rtl/tdm_codec_slot_chk.sv
module tdm_codec_slot_chk (
  input logic clk,
  input logic rst_n,
  input logic rise,
  input logic fall,
  input logic resync,
  input logic at_frame_head,
  input logic dd_en,
  input logic du_en,
  input logic tx_bit,
  input logic rx_valid,
  input logic cfg_intra_q,
  input logic cfg_rev_q,
  input logic cfg_term_q
);

  // R2: never both lines at once
  a_r2_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dd_en, du_en}));

  // R3: drive outputs move only after a rising data-clock edge
  a_r3_hold_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> ($stable(dd_en) && $stable(du_en) && $stable(tx_bit)));

  // R5: downstream is driven only for a reversed intra-chip slot in terminal mode
  a_r5_down_needs_reversal: assert property (@(posedge clk) disable iff (!rst_n)
    dd_en |-> (cfg_intra_q && cfg_rev_q && cfg_term_q));

  // R6: voice slots never drive downstream
  a_r6_voice_slot_upstream: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_intra_q |-> !dd_en);

  // R7: without terminal mode, downstream is never driven
  a_r7_no_term_no_reverse: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_term_q |-> !dd_en);

  // R9: strobe lasts one cycle and follows a falling data-clock edge
  a_r9_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r9_strobe_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(fall));

  // R10: sync puts the position at the head of the frame
  a_r10_sync_realigns: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> at_frame_head);

endmodule

bind tdm_codec_slot tdm_codec_slot_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rise         (rise),
  .fall         (fall),
  .resync       (resync),
  .at_frame_head(at_frame_head),
  .dd_en        (dd_en),
  .du_en        (du_en),
  .tx_bit       (tx_bit),
  .rx_valid     (codec_rx_valid),
  .cfg_intra_q  (cfg_intra_q),
  .cfg_rev_q    (cfg_rev_q),
  .cfg_term_q   (cfg_term_q)
);

// File: tb/tdm_codec_slot_tb_top.sv
module tdm_codec_slot_tb_top;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, dcl, fsc, dd_in, du_in;
  logic [1:0] cfg_slot;
  logic       cfg_reverse, term_mode, cfg_loopback;
  logic [7:0] codec_tx;
  wire        dd_en, du_en, tx_bit;
  wire  [7:0] codec_rx;
  wire        codec_rx_valid;

  int n_chk  = 0;
  int n_fail = 0;
  int rx_cnt = 0;
  logic [7:0] rx_last = '0;
  bit done = 1'b0;

  tdm_codec_slot dut_i (
    .clk(clk), .rst_n(rst_n), .dcl(dcl), .fsc(fsc), .dd_in(dd_in), .du_in(du_in),
    .dd_en(dd_en), .du_en(du_en), .tx_bit(tx_bit), .cfg_slot(cfg_slot),
    .cfg_reverse(cfg_reverse), .term_mode(term_mode), .cfg_loopback(cfg_loopback),
    .codec_tx(codec_tx), .codec_rx(codec_rx), .codec_rx_valid(codec_rx_valid)
  );

  always @(negedge clk) begin
    if (rst_n && codec_rx_valid) begin
      rx_cnt++;
      rx_last = codec_rx;
    end
  end

  function automatic logic [7:0] pat_dd(input int fr, input int by);
    return 8'((8'hA5 ^ (by * 29)) + fr * 7);
  endfunction

  function automatic logic [7:0] pat_du(input int fr, input int by);
    return pat_dd(fr, by) ^ 8'h5A;
  endfunction

  // R2 slot code to frame byte
  function automatic int slot_pos(input logic [1:0] s);
    case (s)
      2'b00:   return 4;
      2'b01:   return 5;
      2'b10:   return 0;
      default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] tx_for(input int fr);
    if (fr == 1) return 8'h00;
    if (fr == 2) return 8'hFF;
    return 8'(8'h96 ^ (fr * 53));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One frame of 192 data-clock periods; abort_at cuts it short, change_at alters inputs mid-frame.
  task automatic run_frame(input int fr, input int abort_at, input int change_at,
                           input logic [1:0] ch_slot, input logic [7:0] ch_tx);
    logic [1:0] e_sel;
    logic       e_rev, e_term, e_lb, dn, insl;
    logic [7:0] e_tx, e_rx;
    int en_err, bit_err;
    bit cut;
    string dtag;
    en_err = 0; bit_err = 0; cut = 0;
    e_sel = cfg_slot; e_rev = cfg_reverse; e_term = term_mode; e_lb = cfg_loopback;
    e_tx = codec_tx;
    dn = !e_sel[1] && e_rev && e_term;
    rx_cnt = 0;
    for (int p = 0; p < 192; p++) begin
      int by, bi;
      if (p == abort_at) begin
        cut = 1;
        break;
      end
      if (p == change_at) begin
        cfg_slot = ch_slot;
        codec_tx = ch_tx;
      end
      by = p / 16;
      bi = (p / 2) % 8;
      @(negedge clk);
      dcl = 1'b1;
      fsc = (p == 0);
      dd_in = pat_dd(fr, by)[7 - bi];
      du_in = pat_du(fr, by)[7 - bi];
      @(negedge clk);
      insl = (by == slot_pos(e_sel));
      if ({dd_en, du_en} !== {insl && dn, insl && !dn}) en_err++;
      if (insl && (tx_bit !== e_tx[7 - bi])) bit_err++;
      if (!insl && (tx_bit !== 1'b1)) bit_err++;
      @(negedge clk);
      dcl = 1'b0;
      @(negedge clk);
    end
    if (e_lb)                    dtag = "R8";
    else if (dn)                 dtag = "R5";
    else if (e_sel[1] && e_rev)  dtag = "R6";
    else if (!e_term && e_rev)   dtag = "R7";
    else                         dtag = "R4";
    chk($sformatf("R2/%s drive window frame %0d", dtag, fr), en_err, 0);
    chk($sformatf("R3 tx bits frame %0d", fr), bit_err, 0);
    if (cut) begin
      chk($sformatf("R10 no strobe on cut slot frame %0d", fr), rx_cnt, 0);
    end else begin
      e_rx = e_lb ? e_tx : (dn ? pat_du(fr, slot_pos(e_sel)) : pat_dd(fr, slot_pos(e_sel)));
      chk($sformatf("R9 one strobe per frame %0d", fr), rx_cnt, 1);
      chk($sformatf("%s/R9 rx byte frame %0d", dtag, fr), rx_last, e_rx);
    end
  endtask

  initial begin
    int fr;
    rst_n = 1'b0; dcl = 1'b0; fsc = 1'b0; dd_in = 1'b1; du_in = 1'b1;
    cfg_slot = 2'b00; cfg_reverse = 1'b0; term_mode = 1'b0; cfg_loopback = 1'b0;
    codec_tx = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 dd_en after reset", dd_en, 0);
    chk("R1 du_en after reset", du_en, 0);
    chk("R1 tx_bit after reset", tx_bit, 1);
    chk("R1 rx_valid after reset", codec_rx_valid, 0);
    chk("R1 rx data after reset", codec_rx, 0);

    fr = 1;
    // Full sweep of slot, reversal, terminal mode and loopback.
    for (int s = 0; s < 4; s++)
      for (int r = 0; r < 2; r++)
        for (int t = 0; t < 2; t++)
          for (int l = 0; l < 2; l++) begin
            cfg_slot = 2'(s); cfg_reverse = 1'(r); term_mode = 1'(t); cfg_loopback = 1'(l);
            codec_tx = tx_for(fr);
            run_frame(fr, -1, -1, 2'b00, 8'h00);
            fr++;
          end

    // R3: mid-frame changes wait for the next frame start.
    cfg_slot = 2'b10; cfg_reverse = 1'b1; term_mode = 1'b1; cfg_loopback = 1'b0;
    codec_tx = 8'hC3;
    run_frame(fr, -1, 20, 2'b00, 8'h5E);
    fr++;
    run_frame(fr, -1, -1, 2'b00, 8'h00);
    fr++;

    // R10: sync lands at bit 3 of the IC1 slot, then a clean frame.
    cfg_slot = 2'b00; cfg_reverse = 1'b0; term_mode = 1'b0; codec_tx = 8'h3B;
    run_frame(fr, 71, -1, 2'b00, 8'h00);
    fr++;
    run_frame(fr, -1, -1, 2'b00, 8'h00);
    fr++;

    repeat (8) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule